// File: doc/BRIEF.md
# Block-Protected Configuration Byte Store

This block holds a 512-byte configuration image that a serial-bus slave front end would read and program. It offers a one-request-per-cycle register-style port. Each request is a single-byte read or write. A read can name its own address, or it can continue from an internal pointer that advances after every accepted access. The image is split into four 128-byte blocks. Each block has a protect flag that software can set or clear with small commands, except for the top block, which stays writable at all times. A write that lands in a protected block is answered normally, but it does not change the stored byte and it raises a sticky flag.

Programming a byte takes time, which the block models with a busy interval of a fixed number of clock cycles after each accepted write. While that interval runs, every request and every command is refused and has no effect. At reset the array is loaded with a computed pattern in which the reserved range reads as zero. The three lower blocks start out protected.

Top module: `cfgstore_top`

## Requirements
- R1: After reset, protMask is 4'b0111 (bit n guards block n, where block n holds addresses n*128 to n*128+127), violation is 0, busy is 0, and the sequential-read pointer is 0.
- R2: After reset, byte i holds (i*37+11) mod 256, except bytes 256 to 319, which hold 00h.
- R3: An accepted read gives ackO=1 and the addressed byte on rdData in the cycle after the request. ackO and nakO are never high together.
- R4: An accepted write (accWrite=1) to an unprotected block stores accWdata. busy is then high for exactly WRITE_CYCLES (default 20) cycles, starting the cycle after the request.
- R5: While busy is high, any request (accValid or cmdValid) gets nakO=1 the next cycle and changes no byte, flag, mask or pointer.
- R6: A write to a protected block gets ackO, leaves the byte unchanged, sets violation, and does not start busy.
- R7: Commands take effect when cmdValid is high. cmdOp=0 sets the protect flag of block cmdBlock, cmdOp=1 clears it, and cmdOp=3 does nothing. Each accepted command gets ackO. Block 3 can never be protected.
- R8: violation stays set until an accepted command with cmdOp=2 clears it.
- R9: With accSeq=1, the access uses the pointer instead of accAddr. After every accepted access, the pointer becomes the used address plus one, wrapping from 1FFh to 000h.
- R10: If accValid and cmdValid are high in the same cycle, the access is served and the command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Byte access request |
| accWrite | input | 1 | 1 = write, 0 = read |
| accSeq | input | 1 | Use the internal pointer as the address |
| accAddr | input | 9 | Byte address |
| accWdata | input | 8 | Write byte |
| cmdValid | input | 1 | Protection command request |
| cmdOp | input | 2 | 0 protect, 1 unprotect, 2 clear flag, 3 none |
| cmdBlock | input | 2 | Block index for the command |
| ackO | output | 1 | Request accepted (one cycle after the request) |
| nakO | output | 1 | Request refused while busy |
| rdData | output | 8 | Read byte |
| busy | output | 1 | Programming interval active |
| violation | output | 1 | Sticky protected-write flag |
| protMask | output | 4 | Per-block protect flags |

## Verification
If the busy counter holds a wrong value, it shows as early or late nakO/ackO on the very next request, and the bench checks busy on every cycle. If a protect flag is wrong, it shows as a changed byte on the following read-back, or as a missing violation one cycle after the write. If the pointer is wrong, it shows up on the next sequential read. A full sequential sweep that wraps past 1FFh exposes any corrupt initial byte within 513 cycles of reset.

// File: rtl/cfgstore_pkg.sv
`timescale 1ns/1ps
package cfgstore_pkg;
  typedef enum logic [1:0] {
    OP_PROTECT   = 2'd0,
    OP_UNPROTECT = 2'd1,
    OP_CLRFLAG   = 2'd2,
    OP_NONE      = 2'd3
  } cmd_op_e;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } store_strobe_t;
endpackage

// File: rtl/cfgstore_store.sv
`timescale 1ns/1ps
module cfgstore_store
  import cfgstore_pkg::*;
#(
  parameter int DEPTH    = 512,
  parameter int AW       = 9,
  parameter int DW       = 8,
  parameter int INIT_MUL = 37,
  parameter int INIT_ADD = 11,
  parameter int RSV_LO   = 256,
  parameter int RSV_HI   = 319
) (
  input  logic          clk,
  input  logic          rstN,
  input  store_strobe_t strb,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdData
);
  logic [DW-1:0] mem     [DEPTH];
  logic [DW-1:0] initTab [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_init
      if (g >= RSV_LO && g <= RSV_HI) begin : g_rsv
        assign initTab[g] = '0;
      end else begin : g_pat
        assign initTab[g] = DW'((g * INIT_MUL + INIT_ADD) % (1 << DW));
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= initTab[i];
    end else if (strb.wrEn) begin
      mem[addr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdEn) rdData <= mem[addr];
  end
endmodule

// File: rtl/cfgstore_ctrl.sv
`timescale 1ns/1ps
module cfgstore_ctrl
  import cfgstore_pkg::*;
#(
  parameter int NUM_BLOCKS   = 4,
  parameter int AW           = 9,
  parameter int BW           = 2,
  parameter int WRITE_CYCLES = 20,
  parameter logic [NUM_BLOCKS-1:0] PROT_DEFAULT = 4'b0111,
  parameter logic [NUM_BLOCKS-1:0] PROT_ALLOWED = 4'b0111
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  accValid,
  input  logic                  accWrite,
  input  logic                  accSeq,
  input  logic [AW-1:0]         accAddr,
  input  logic                  cmdValid,
  input  logic [1:0]            cmdOp,
  input  logic [BW-1:0]         cmdBlock,
  output store_strobe_t         strb,
  output logic [AW-1:0]         effAddr,
  output logic                  ackO,
  output logic                  nakO,
  output logic                  busy,
  output logic                  violation,
  output logic [NUM_BLOCKS-1:0] protMask
);
  localparam int CW = $clog2(WRITE_CYCLES + 1);

  logic [CW-1:0]         busyCnt;
  logic [AW-1:0]         ptr;
  logic                  accGo, cmdGo, blkProt;
  logic [NUM_BLOCKS-1:0] cmdSel;

  assign busy    = (busyCnt != '0);
  assign effAddr = accSeq ? ptr : accAddr;
  assign blkProt = protMask[effAddr[AW-1 -: BW]];
  assign accGo   = accValid && !busy;
  assign cmdGo   = cmdValid && !accValid && !busy;
  assign cmdSel  = NUM_BLOCKS'(1) << cmdBlock;

  always_comb begin
    strb.rdEn = accGo && !accWrite;
    strb.wrEn = accGo && accWrite && !blkProt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackO <= 1'b0;
      nakO <= 1'b0;
    end else begin
      ackO <= accGo || cmdGo;
      nakO <= busy && (accValid || cmdValid);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          busyCnt <= '0;
    else if (strb.wrEn) busyCnt <= CW'(WRITE_CYCLES);
    else if (busy)      busyCnt <= busyCnt - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)      ptr <= '0;
    else if (accGo) ptr <= effAddr + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                  violation <= 1'b0;
    else if (accGo && accWrite && blkProt)      violation <= 1'b1;
    else if (cmdGo && cmdOp == OP_CLRFLAG)      violation <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) protMask <= PROT_DEFAULT & PROT_ALLOWED;
    else if (cmdGo) begin
      if (cmdOp == OP_PROTECT)   protMask <= protMask | (cmdSel & PROT_ALLOWED);
      if (cmdOp == OP_UNPROTECT) protMask <= protMask & ~cmdSel;
    end
  end
endmodule

// File: rtl/cfgstore_top.sv
`timescale 1ns/1ps
module cfgstore_top
  import cfgstore_pkg::*;
#(
  parameter int NUM_BLOCKS   = 4,
  parameter int BLOCK_BYTES  = 128,
  parameter int DW           = 8,
  parameter int WRITE_CYCLES = 20,
  parameter int INIT_MUL     = 37,
  parameter int INIT_ADD     = 11,
  parameter int RSV_LO       = 256,
  parameter int RSV_HI       = 319,
  parameter logic [NUM_BLOCKS-1:0] PROT_DEFAULT = 4'b0111,
  parameter logic [NUM_BLOCKS-1:0] PROT_ALLOWED = 4'b0111,
  localparam int DEPTH = NUM_BLOCKS * BLOCK_BYTES,
  localparam int AW    = $clog2(DEPTH),
  localparam int BW    = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  accValid,
  input  logic                  accWrite,
  input  logic                  accSeq,
  input  logic [AW-1:0]         accAddr,
  input  logic [DW-1:0]         accWdata,
  input  logic                  cmdValid,
  input  logic [1:0]            cmdOp,
  input  logic [BW-1:0]         cmdBlock,
  output logic                  ackO,
  output logic                  nakO,
  output logic [DW-1:0]         rdData,
  output logic                  busy,
  output logic                  violation,
  output logic [NUM_BLOCKS-1:0] protMask
);
  store_strobe_t strb;
  logic [AW-1:0] effAddr;

  cfgstore_ctrl #(
    .NUM_BLOCKS(NUM_BLOCKS), .AW(AW), .BW(BW), .WRITE_CYCLES(WRITE_CYCLES),
    .PROT_DEFAULT(PROT_DEFAULT), .PROT_ALLOWED(PROT_ALLOWED)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accSeq(accSeq), .accAddr(accAddr), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdBlock(cmdBlock), .strb(strb), .effAddr(effAddr), .ackO(ackO),
    .nakO(nakO), .busy(busy), .violation(violation), .protMask(protMask)
  );

  cfgstore_store #(
    .DEPTH(DEPTH), .AW(AW), .DW(DW), .INIT_MUL(INIT_MUL),
    .INIT_ADD(INIT_ADD), .RSV_LO(RSV_LO), .RSV_HI(RSV_HI)
  ) store_i (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(effAddr),
    .wdata(accWdata), .rdData(rdData)
  );
endmodule

// File: rtl/cfgstore_chk.sv
`timescale 1ns/1ps
module cfgstore_chk #(
  parameter int NUM_BLOCKS = 4,
  parameter int AW         = 9,
  parameter int BW         = 2
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  accValid,
  input logic                  accWrite,
  input logic                  accSeq,
  input logic [AW-1:0]         accAddr,
  input logic                  cmdValid,
  input logic [1:0]            cmdOp,
  input logic                  ackO,
  input logic                  nakO,
  input logic                  busy,
  input logic                  violation,
  input logic [NUM_BLOCKS-1:0] protMask
);
  // R3
  ack_nak_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ackO && nakO));

  // R5
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && busy) |=> (nakO && !ackO));

  // R4
  wr_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accWrite && !accSeq && !busy && !protMask[accAddr[AW-1 -: BW]]) |=> busy);

  // R6
  prot_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accWrite && !accSeq && !busy && protMask[accAddr[AW-1 -: BW]])
      |=> (violation && !busy && ackO));

  // R7
  top_blk_chk: assert property (@(posedge clk) disable iff (!rstN)
    !protMask[NUM_BLOCKS-1]);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (violation && !(cmdValid && !accValid && !busy && cmdOp == 2'd2)) |=> violation);

  // R10
  cmd_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && cmdValid) |=> $stable(protMask));
endmodule

bind cfgstore_top cfgstore_chk #(.NUM_BLOCKS(NUM_BLOCKS), .AW(AW), .BW(BW)) chk_i (
  .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
  .accSeq(accSeq), .accAddr(accAddr), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .ackO(ackO), .nakO(nakO), .busy(busy), .violation(violation),
  .protMask(protMask)
);

// File: tb/cfgstore_top_tb_top.sv
`timescale 1ns/1ps
module cfgstore_top_tb_top;
  localparam int WCYC = 20;
  localparam int DEP  = 512;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       accValid = 0, accWrite = 0, accSeq = 0;
  logic [8:0] accAddr = '0;
  logic [7:0] accWdata = '0;
  logic       cmdValid = 0;
  logic [1:0] cmdOp = '0;
  logic [1:0] cmdBlock = '0;
  logic       ackO, nakO, busy, violation;
  logic [7:0] rdData;
  logic [3:0] protMask;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] mMem [DEP];
  logic [3:0] mProt;
  logic       mViol;
  int         mPtr, mBusy;

  always #2.5 clk = ~clk;

  cfgstore_top #(.WRITE_CYCLES(WCYC)) dut_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accSeq(accSeq), .accAddr(accAddr), .accWdata(accWdata),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdBlock(cmdBlock), .ackO(ackO),
    .nakO(nakO), .rdData(rdData), .busy(busy), .violation(violation),
    .protMask(protMask)
  );

  function automatic logic [7:0] initByte(int i);
    if (i >= 256 && i <= 319) return 8'h00;
    return 8'((i * 37 + 11) % 256);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(bit aV, bit aW, bit aS, int a, int d,
                      bit cV, int op, int blk, string tag);
    bit expAck = 0, expNak = 0, chkRd = 0, setBusy = 0;
    int eff, b;
    logic [7:0] expRd = '0;
    @(negedge clk);
    accValid = aV; accWrite = aW; accSeq = aS; accAddr = 9'(a);
    accWdata = 8'(d); cmdValid = cV; cmdOp = 2'(op); cmdBlock = 2'(blk);
    eff = aS ? mPtr : a;
    b = eff / 128;
    if (aV) begin
      if (mBusy != 0) expNak = 1;
      else begin
        expAck = 1;
        if (aW) begin
          if (mProt[b]) mViol = 1;
          else begin mMem[eff] = 8'(d); setBusy = 1; end
        end else begin chkRd = 1; expRd = mMem[eff]; end
        mPtr = (eff + 1) % DEP;
      end
    end else if (cV) begin
      if (mBusy != 0) expNak = 1;
      else begin
        expAck = 1;
        case (op)
          0: if (blk != 3) mProt[blk] = 1'b1;
          1: mProt[blk] = 1'b0;
          2: mViol = 0;
          default: ;
        endcase
      end
    end
    if (setBusy) mBusy = WCYC;
    else if (mBusy > 0) mBusy--;
    @(posedge clk);
    #1;
    chk(ackO == expAck, {tag, " ack"}, ackO, expAck);
    chk(nakO == expNak, {tag, " nak"}, nakO, expNak);
    chk(busy == (mBusy != 0), {tag, " busy"}, busy, mBusy != 0);
    chk(violation == mViol, {tag, " violation"}, violation, mViol);
    chk(protMask == mProt, {tag, " protMask"}, protMask, mProt);
    if (chkRd) chk(rdData == expRd, {tag, " rdData"}, rdData, expRd);
    accValid = 0; cmdValid = 0;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    for (int i = 0; i < DEP; i++) mMem[i] = initByte(i);
    mProt = 4'b0111; mViol = 0; mPtr = 0; mBusy = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    // R1 reset state
    chk(protMask == 4'b0111, "R1 protMask", protMask, 4'b0111);
    chk(violation == 0, "R1 violation", violation, 0);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(ackO == 0 && nakO == 0, "R1 handshake", {ackO, nakO}, 0);

    // R2 / R9: sweep the whole array sequentially from pointer 0, then wrap
    for (int i = 0; i < DEP + 2; i++) step(1, 0, 1, 0, 0, 0, 0, 0, "R2 R9 sweep");

    // R3 addressed reads
    step(1, 0, 0, 300, 0, 0, 0, 0, "R3 reserved read");
    step(1, 0, 0, 511, 0, 0, 0, 0, "R3 top read");
    step(1, 0, 1, 0, 0, 0, 0, 0, "R9 wrap after 1FF");

    // R4 write to unprotected top block and busy length
    step(1, 1, 0, 400, 8'hA5, 0, 0, 0, "R4 write");
    // R5 refused access and command during busy
    step(1, 1, 0, 401, 8'h5A, 0, 0, 0, "R5 write while busy");
    step(0, 0, 0, 0, 0, 1, 1, 0, "R5 cmd while busy");
    idle(WCYC - 3, "R4 busy window");
    step(1, 0, 0, 401, 0, 0, 0, 0, "R5 last busy read");
    step(1, 0, 0, 400, 0, 0, 0, 0, "R4 readback");
    step(1, 0, 0, 401, 0, 0, 0, 0, "R5 untouched byte");

    // R6 protected write
    step(1, 1, 0, 5, 8'h77, 0, 0, 0, "R6 protected write");
    step(1, 0, 0, 5, 0, 0, 0, 0, "R6 byte unchanged");

    // R7 protection commands
    step(0, 0, 0, 0, 0, 1, 1, 0, "R7 unprotect block0");
    step(1, 1, 0, 5, 8'h77, 0, 0, 0, "R7 write after unprotect");
    idle(WCYC, "R7 wait");
    step(1, 0, 0, 5, 0, 0, 0, 0, "R7 readback");
    step(0, 0, 0, 0, 0, 1, 0, 3, "R7 protect block3 refused");
    step(0, 0, 0, 0, 0, 1, 0, 0, "R7 protect block0");
    step(0, 0, 0, 0, 0, 1, 3, 1, "R7 no-op command");

    // R8 clear flag
    step(0, 0, 0, 0, 0, 1, 2, 0, "R8 clear violation");

    // R10 simultaneous access and command
    step(1, 0, 0, 130, 0, 1, 1, 1, "R10 cmd dropped");

    // Constrained random mix
    for (int n = 0; n < 1500; n++) begin
      int r = $urandom_range(0, 9);
      if (r < 4)      step(1, 0, $urandom_range(0, 1), $urandom_range(0, 511), 0, 0, 0, 0, "R3 R9 random read");
      else if (r < 7) step(1, 1, $urandom_range(0, 1), $urandom_range(0, 511), $urandom_range(0, 255), 0, 0, 0, "R4 R6 random write");
      else if (r < 9) step(0, 0, 0, 0, 0, 1, $urandom_range(0, 3), $urandom_range(0, 3), "R7 R8 random cmd");
      else            step(1, 0, 0, $urandom_range(0, 511), 0, 1, $urandom_range(0, 3), $urandom_range(0, 3), "R10 random clash");
    end

    idle(WCYC + 1, "R4 drain");
    for (int i = 0; i < 40; i++) step(1, 0, 1, 0, 0, 0, 0, 0, "R2 final sweep");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule